// File: doc/BRIEF.md
# Deferred Register Accumulate Writeback Controller

This block sits beside the register file of a stack processor. It lets an ordinary ALU instruction accumulate into a register with no separate read, modify and write steps. An accumulate instruction names a register. In the same cycle, the block reads that register and places its value on the operand stack, either as the new top or tucked directly beneath the current top. It also arms a pending writeback. A later instruction then produces an ALU result, and the block steers that result back into the same register. The registers occupy the lowest memory addresses, and register 0 is the program counter.

Each accumulate carries a delay field k. The writeback takes the ALU result of the (k+1)-th instruction that retires after the accumulate, so k = 0 targets the very next instruction. While a writeback is waiting, the target register and the remaining count are held in a small state register, and both are visible at the ports. One further accumulate may be queued behind a pending one. If the instruction that should supply the result produces no ALU result, the writeback is dropped and an error pulse is raised. A build parameter moves the register-file write into the following cycle for timing.

Top module: `acc_writeback_ctl`

## Requirements
- R1: A retiring accumulate-to-top instruction (ins_op = 1) that is not refused drives rf_rd_en, rf_rd_addr = ins_reg and stk_push in its own cycle, with stk_data equal to the value read, and the block then holds a pending writeback.
- R2: A retiring accumulate-beneath instruction (ins_op = 2) does the same, but asserts stk_insert instead of stk_push. stk_push and stk_insert are never high together. Codes 0 and 3 are plain instructions.
- R3: With delay field k, the writeback happens on the (k+1)-th retiring instruction (ins_valid high) after arming, in that instruction's cycle, with the data on alu_data. Earlier instructions cause no write. Cycles with ins_valid low do not count.
- R4: pend_valid, pend_reg and pend_left show the armed writeback. pend_left starts at k and falls by one on each retiring instruction until it reaches 0.
- R5: If the instruction that reaches the writeback is an accumulate, or does not have alu_valid high, no register is written, drop_err pulses in that cycle, and the pending writeback is cleared.
- R6: An accumulate that retires while one is already pending counts as an instruction toward the older one and is queued (queued = 1). It becomes pending only once the older writeback has resolved, and the instruction that resolves the older one does not count toward it.
- R7: An accumulate that arrives while the queue is occupied and the older writeback is not resolving in that cycle is refused. It causes no read and no stack operation, refuse_err pulses, and it still counts toward the older writeback.
- R8: The write address equals the armed register index, including register 0.
- R9: Reset clears both the pending and the queued writeback, and no write follows from anything armed before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | An instruction retires this cycle |
| ins_op | input | 2 | 0/3 plain, 1 accumulate to top, 2 accumulate beneath top |
| ins_reg | input | REG_AW | Register index of an accumulate |
| ins_after | input | CNT_W | Delay field k of an accumulate |
| alu_valid | input | 1 | The retiring instruction produces an ALU result |
| alu_data | input | DATA_W | ALU result |
| rf_rd_en | output | 1 | Register file read strobe |
| rf_rd_addr | output | REG_AW | Register file read index |
| rf_rd_data | input | DATA_W | Register file read data (same cycle) |
| stk_push | output | 1 | Push stk_data as new top of stack |
| stk_insert | output | 1 | Insert stk_data beneath the top of stack |
| stk_data | output | DATA_W | Value sent to the stack |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_addr | output | REG_AW | Register file write index |
| rf_wr_data | output | DATA_W | Register file write data |
| drop_err | output | 1 | Writeback dropped this cycle |
| refuse_err | output | 1 | Accumulate refused this cycle |
| pend_valid | output | 1 | A writeback is armed |
| pend_reg | output | REG_AW | Target register of the armed writeback |
| pend_left | output | CNT_W | Retiring instructions still to pass |
| queued | output | 1 | A second accumulate waits behind the armed one |

## Verification
The bench aims at count boundaries. A design off by one in the countdown would write the result of the neighbouring instruction. A design that counted idle cycles would write too early. It drives an accumulate that lands exactly on the resolving instruction of an older one; a design that skipped the queue or counted the resolving instruction for the newer one would then hit the wrong register or the wrong cycle. It also drives a third accumulate against a full queue, where a faulty design would push a stray operand. Further cases are a missing ALU result on the due instruction, which should produce no write, and a reset during a pending writeback, after which no write should occur.

// File: rtl/acc_wb_pkg.sv
package acc_wb_pkg;

    localparam int DEF_DATA_W = 16;
    localparam int DEF_REG_AW = 4;
    localparam int DEF_CNT_W  = 4;

    typedef enum logic [1:0] {
        OP_PLAIN     = 2'd0,
        OP_ACC_TOP   = 2'd1,
        OP_ACC_UNDER = 2'd2,
        OP_PLAIN_ALT = 2'd3
    } acc_op_e;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_WRITE = 2'd1,
        RES_DROP  = 2'd2
    } res_e;

    function automatic logic op_is_acc(input logic [1:0] op);
        return (op == OP_ACC_TOP) || (op == OP_ACC_UNDER);
    endfunction

    function automatic logic op_is_under(input logic [1:0] op);
        return op == OP_ACC_UNDER;
    endfunction

endpackage

// File: rtl/acc_tracker.sv
module acc_tracker
    import acc_wb_pkg::*;
#(
    parameter int REG_AW = DEF_REG_AW,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [1:0]        ins_op,
    input  logic [REG_AW-1:0] ins_reg,
    input  logic [CNT_W-1:0]  ins_after,
    input  logic              alu_valid,
    output res_e              res_kind,
    output logic [REG_AW-1:0] res_reg,
    output logic              refuse,
    output logic              pend_valid,
    output logic [REG_AW-1:0] pend_reg,
    output logic [CNT_W-1:0]  pend_left,
    output logic              queued
);

    typedef struct packed {
        logic              vld;
        logic [REG_AW-1:0] rg;
        logic [CNT_W-1:0]  left;
    } slot_t;

    slot_t pend_q, que_q, pend_d, que_d, fresh;
    logic  is_acc, counts, due, due_ok;

    always_comb begin
        is_acc = ins_valid && op_is_acc(ins_op);
        counts = ins_valid && pend_q.vld;
        due    = counts && (pend_q.left == '0);
        due_ok = due && !is_acc && alu_valid;
        refuse = is_acc && que_q.vld && !due;

        fresh.vld  = 1'b1;
        fresh.rg   = ins_reg;
        fresh.left = ins_after;

        pend_d = pend_q;
        que_d  = que_q;
        if (counts && !due) begin
            pend_d.left = pend_q.left - 1'b1;
        end
        if (due) begin
            pend_d = que_q;
            que_d  = '0;
        end
        if (is_acc && !refuse) begin
            if (!pend_d.vld) begin
                pend_d = fresh;
            end else begin
                que_d = fresh;
            end
        end

        if (due_ok) begin
            res_kind = RES_WRITE;
        end else if (due) begin
            res_kind = RES_DROP;
        end else begin
            res_kind = RES_NONE;
        end
        res_reg = pend_q.rg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            que_q  <= '0;
        end else begin
            pend_q <= pend_d;
            que_q  <= que_d;
        end
    end

    assign pend_valid = pend_q.vld;
    assign pend_reg   = pend_q.rg;
    assign pend_left  = pend_q.left;
    assign queued     = que_q.vld;

endmodule

// File: rtl/acc_fetch.sv
module acc_fetch
    import acc_wb_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int REG_AW = DEF_REG_AW
) (
    input  logic              ins_valid,
    input  logic [1:0]        ins_op,
    input  logic [REG_AW-1:0] ins_reg,
    input  logic              refuse,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_rd_en,
    output logic [REG_AW-1:0] rf_rd_addr,
    output logic              stk_push,
    output logic              stk_insert,
    output logic [DATA_W-1:0] stk_data
);

    always_comb begin
        rf_rd_en   = ins_valid && op_is_acc(ins_op) && !refuse;
        rf_rd_addr = ins_reg;
        stk_insert = rf_rd_en && op_is_under(ins_op);
        stk_push   = rf_rd_en && !op_is_under(ins_op);
        stk_data   = rf_rd_en ? rf_rd_data : '0;
    end

endmodule

// File: rtl/acc_writeback_ctl.sv
module acc_writeback_ctl
    import acc_wb_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int REG_AW = DEF_REG_AW,
    parameter int CNT_W  = DEF_CNT_W,
    parameter bit WB_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [1:0]        ins_op,
    input  logic [REG_AW-1:0] ins_reg,
    input  logic [CNT_W-1:0]  ins_after,
    input  logic              alu_valid,
    input  logic [DATA_W-1:0] alu_data,
    output logic              rf_rd_en,
    output logic [REG_AW-1:0] rf_rd_addr,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              stk_push,
    output logic              stk_insert,
    output logic [DATA_W-1:0] stk_data,
    output logic              rf_wr_en,
    output logic [REG_AW-1:0] rf_wr_addr,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              drop_err,
    output logic              refuse_err,
    output logic              pend_valid,
    output logic [REG_AW-1:0] pend_reg,
    output logic [CNT_W-1:0]  pend_left,
    output logic              queued
);

    res_e              res_kind;
    logic [REG_AW-1:0] res_reg;
    logic              refuse;

    acc_tracker #(.REG_AW(REG_AW), .CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .ins_valid  (ins_valid),
        .ins_op     (ins_op),
        .ins_reg    (ins_reg),
        .ins_after  (ins_after),
        .alu_valid  (alu_valid),
        .res_kind   (res_kind),
        .res_reg    (res_reg),
        .refuse     (refuse),
        .pend_valid (pend_valid),
        .pend_reg   (pend_reg),
        .pend_left  (pend_left),
        .queued     (queued)
    );

    acc_fetch #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_fetch (
        .ins_valid  (ins_valid),
        .ins_op     (ins_op),
        .ins_reg    (ins_reg),
        .refuse     (refuse),
        .rf_rd_data (rf_rd_data),
        .rf_rd_en   (rf_rd_en),
        .rf_rd_addr (rf_rd_addr),
        .stk_push   (stk_push),
        .stk_insert (stk_insert),
        .stk_data   (stk_data)
    );

    assign refuse_err = refuse;
    assign drop_err   = (res_kind == RES_DROP);

    generate
        if (WB_REG) begin : g_wb_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    rf_wr_en   <= 1'b0;
                    rf_wr_addr <= '0;
                    rf_wr_data <= '0;
                end else begin
                    rf_wr_en   <= (res_kind == RES_WRITE);
                    rf_wr_addr <= res_reg;
                    rf_wr_data <= alu_data;
                end
            end
        end else begin : g_wb_comb
            assign rf_wr_en   = (res_kind == RES_WRITE);
            assign rf_wr_addr = res_reg;
            assign rf_wr_data = alu_data;
        end
    endgenerate

endmodule

// File: rtl/acc_wb_chk.sv
module acc_wb_chk #(
    parameter int DATA_W = 16,
    parameter int REG_AW = 4,
    parameter int CNT_W  = 4,
    parameter bit WB_REG = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              ins_valid,
    input logic              alu_valid,
    input logic              rf_rd_en,
    input logic              stk_push,
    input logic              stk_insert,
    input logic              rf_wr_en,
    input logic [REG_AW-1:0] rf_wr_addr,
    input logic              drop_err,
    input logic              refuse_err,
    input logic              pend_valid,
    input logic [REG_AW-1:0] pend_reg,
    input logic [CNT_W-1:0]  pend_left,
    input logic              queued
);

    // R1
    push_arms_chk: assert property (@(posedge clk) disable iff (rst)
        stk_push |=> pend_valid);

    // R2
    one_stack_op_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stk_push, stk_insert}));

    // R4
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && ins_valid && pend_left != '0) |=>
        (pend_valid && pend_left == CNT_W'($past(pend_left) - 1'b1)));

    // R6
    queue_behind_chk: assert property (@(posedge clk) disable iff (rst)
        queued |-> pend_valid);

    // R7
    refuse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        refuse_err |-> (!rf_rd_en && !stk_push && !stk_insert));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!pend_valid && !queued));

    generate
        if (!WB_REG) begin : g_comb_chk
            // R3
            write_when_due_chk: assert property (@(posedge clk) disable iff (rst)
                rf_wr_en |-> (pend_valid && pend_left == '0 && ins_valid && alu_valid));
            // R8
            write_addr_chk: assert property (@(posedge clk) disable iff (rst)
                rf_wr_en |-> (rf_wr_addr == pend_reg));
            // R5
            drop_no_write_chk: assert property (@(posedge clk) disable iff (rst)
                drop_err |-> (!rf_wr_en && pend_valid));
        end
    endgenerate

endmodule

bind acc_writeback_ctl acc_wb_chk #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .CNT_W(CNT_W), .WB_REG(WB_REG)
) u_acc_wb_chk (.*);

// File: tb/test_acc_writeback_ctl.sv
module test_acc_writeback_ctl;

    localparam int DW = 16;
    localparam int AW = 4;
    localparam int CW = 4;

    typedef struct packed {
        logic          iv;
        logic [1:0]    op;
        logic [AW-1:0] rg;
        logic [CW-1:0] aft;
        logic          av;
        logic [DW-1:0] ad;
        logic          e_push;
        logic          e_ins;
        logic          e_wr;
        logic [AW-1:0] e_wa;
        logic [DW-1:0] e_wd;
        logic          e_drop;
        logic          e_ref;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd1, 4'd3,  4'd0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b1, 4'd3,  16'h1234, 1'b0, 1'b0},
        '{1'b1, 2'd2, 4'd5,  4'd2, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd3, 4'd0,  4'd0, 1'b1, 16'h0AAA, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h0BBB, 1'b0, 1'b0, 1'b1, 4'd5,  16'h0BBB, 1'b0, 1'b0},
        '{1'b1, 2'd1, 4'd7,  4'd1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd1, 4'd2,  4'd0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h0C0C, 1'b0, 1'b0, 1'b1, 4'd7,  16'h0C0C, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h0D0D, 1'b0, 1'b0, 1'b1, 4'd2,  16'h0D0D, 1'b0, 1'b0},
        '{1'b1, 2'd1, 4'd4,  4'd0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b0, 16'h4444, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b1, 1'b0},
        '{1'b1, 2'd1, 4'd6,  4'd0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd1, 4'd8,  4'd3, 1'b1, 16'h6666, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b1, 1'b0},
        '{1'b0, 2'd0, 4'd0,  4'd0, 1'b1, 16'h5555, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h1001, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h1002, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h1003, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h0E0E, 1'b0, 1'b0, 1'b1, 4'd8,  16'h0E0E, 1'b0, 1'b0},
        '{1'b1, 2'd1, 4'd9,  4'd5, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd2, 4'd10, 4'd5, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd1, 4'd11, 4'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b1},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h2001, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h2002, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h2003, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h0F0F, 1'b0, 1'b0, 1'b1, 4'd9,  16'h0F0F, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h3001, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd3, 4'd0,  4'd0, 1'b1, 16'h3002, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h3003, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h3004, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h3005, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h1111, 1'b0, 1'b0, 1'b1, 4'd10, 16'h1111, 1'b0, 1'b0},
        '{1'b1, 2'd1, 4'd0,  4'd0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd0, 4'd0,  4'd0, 1'b1, 16'h2222, 1'b0, 1'b0, 1'b1, 4'd0,  16'h2222, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ins_valid = 1'b0;
    logic [1:0]    ins_op = 2'd0;
    logic [AW-1:0] ins_reg = '0;
    logic [CW-1:0] ins_after = '0;
    logic          alu_valid = 1'b0;
    logic [DW-1:0] alu_data = '0;
    logic          rf_rd_en, stk_push, stk_insert, rf_wr_en;
    logic          drop_err, refuse_err, pend_valid, queued;
    logic [AW-1:0] rf_rd_addr, rf_wr_addr, pend_reg;
    logic [CW-1:0] pend_left;
    logic [DW-1:0] rf_rd_data, stk_data, rf_wr_data;

    logic [DW-1:0] rf  [16];
    logic [DW-1:0] mrf [16];

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    acc_writeback_ctl i_acc_writeback_ctl (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_op(ins_op),
        .ins_reg(ins_reg), .ins_after(ins_after), .alu_valid(alu_valid),
        .alu_data(alu_data), .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr),
        .rf_rd_data(rf_rd_data), .stk_push(stk_push), .stk_insert(stk_insert),
        .stk_data(stk_data), .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr),
        .rf_wr_data(rf_wr_data), .drop_err(drop_err), .refuse_err(refuse_err),
        .pend_valid(pend_valid), .pend_reg(pend_reg), .pend_left(pend_left),
        .queued(queued)
    );

    assign rf_rd_data = rf[rf_rd_addr];

    always_ff @(posedge clk) begin
        if (rf_wr_en) rf[rf_wr_addr] <= rf_wr_data;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic iv, input logic [1:0] op, input logic [AW-1:0] rg,
                         input logic [CW-1:0] aft, input logic av, input logic [DW-1:0] ad);
        @(negedge clk);
        ins_valid = iv; ins_op = op; ins_reg = rg; ins_after = aft;
        alu_valid = av; alu_data = ad;
        #2;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            rf[i]  = 16'hA000 + 16'(i) * 16'h0101;
            mrf[i] = 16'hA000 + 16'(i) * 16'h0101;
        end
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset pend_valid", 32'(pend_valid), 32'd0);
        check("R9 reset queued", 32'(queued), 32'd0);
        check("R9 reset wr_en", 32'(rf_wr_en), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].iv, TBL[i].op, TBL[i].rg, TBL[i].aft, TBL[i].av, TBL[i].ad);
            check("R1 push", 32'(stk_push), 32'(TBL[i].e_push));
            check("R2 insert", 32'(stk_insert), 32'(TBL[i].e_ins));
            if (TBL[i].e_push || TBL[i].e_ins) begin
                check("R1 read addr", 32'(rf_rd_addr), 32'(TBL[i].rg));
                check("R1 stack data", 32'(stk_data), 32'(mrf[TBL[i].rg]));
            end
            check("R3 write enable", 32'(rf_wr_en), 32'(TBL[i].e_wr));
            if (TBL[i].e_wr) begin
                check("R8 write addr", 32'(rf_wr_addr), 32'(TBL[i].e_wa));
                check("R3 write data", 32'(rf_wr_data), 32'(TBL[i].e_wd));
                mrf[TBL[i].e_wa] = TBL[i].e_wd;
            end
            check("R5 drop", 32'(drop_err), 32'(TBL[i].e_drop));
            check("R7 refuse", 32'(refuse_err), 32'(TBL[i].e_ref));
        end
        settle();
        check("R5 idle after table", 32'(pend_valid), 32'd0);

        // R4 countdown visible at the ports
        drive(1'b1, 2'd2, 4'd12, 4'd2, 1'b0, '0);
        settle();
        check("R4 pend_valid", 32'(pend_valid), 32'd1);
        check("R4 pend_reg", 32'(pend_reg), 32'd12);
        check("R4 pend_left", 32'(pend_left), 32'd2);
        drive(1'b1, 2'd0, 4'd0, 4'd0, 1'b0, '0);
        settle();
        check("R4 pend_left step", 32'(pend_left), 32'd1);
        drive(1'b0, 2'd0, 4'd0, 4'd0, 1'b1, 16'h7777);
        check("R3 idle no write", 32'(rf_wr_en), 32'd0);
        settle();
        check("R3 idle no count", 32'(pend_left), 32'd1);
        drive(1'b1, 2'd0, 4'd0, 4'd0, 1'b1, 16'h7070);
        check("R3 early no write", 32'(rf_wr_en), 32'd0);
        settle();
        check("R4 pend_left zero", 32'(pend_left), 32'd0);
        drive(1'b1, 2'd0, 4'd0, 4'd0, 1'b1, 16'h7171);
        check("R3 due write", 32'(rf_wr_en), 32'd1);
        check("R8 due addr", 32'(rf_wr_addr), 32'd12);
        settle();
        check("R4 cleared", 32'(pend_valid), 32'd0);
        check("R3 register file", 32'(rf[12]), 32'h7171);

        // R6 queue state, then R9 reset while armed
        drive(1'b1, 2'd1, 4'd1, 4'd1, 1'b0, '0);
        drive(1'b1, 2'd1, 4'd2, 4'd0, 1'b0, '0);
        settle();
        check("R6 queued", 32'(queued), 32'd1);
        check("R6 older pending", 32'(pend_reg), 32'd1);
        @(negedge clk);
        ins_valid = 1'b0;
        rst = 1'b1;
        settle();
        @(negedge clk);
        rst = 1'b0;
        check("R9 pend cleared", 32'(pend_valid), 32'd0);
        check("R9 queue cleared", 32'(queued), 32'd0);
        drive(1'b1, 2'd0, 4'd0, 4'd0, 1'b1, 16'h9999);
        check("R9 no write after reset", 32'(rf_wr_en), 32'd0);
        settle();
        ins_valid = 1'b0;

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule